// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block receives asynchronous serial bytes framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit, with no parity. The raw receive line is synchronised to the system clock. A programmable divisor produces an oversampling enable at sixteen times the bit rate. Each received byte appears on a parallel output together with a one-cycle valid strobe and a framing-error flag.

Every bit is decided by a two-of-three majority vote over its oversamples 7, 8 and 9, counted from 0 at the bit's leading edge. The start bit gets the same vote, so a short low pulse on an idle line is dropped. The receiver rearms for the next start edge as soon as the stop bit has been voted, which is halfway through the stop bit. When a transition between two data bits is seen one oversample early or late, the bit phase is moved by one oversample. This lets the receiver follow a sender whose rate is slightly off.

Top module: `uart_os_rx`

## Requirements
- R1: After synchronous active-low reset, valid_o is 0, data_o is 0 and frame_err_o is 0, and the receiver is idle.
- R2: The oversampling enable fires once every baud_div_i+1 clocks, and one bit lasts 16 enables. The bench therefore sends each bit for 16*(baud_div_i+1) clocks.
- R3: While idle, a high-to-low transition of the synchronised line starts a frame at oversample 0. If the majority of oversamples 7, 8 and 9 of the start bit is high, the event is a glitch: no byte is produced and the receiver goes back to idle. For example, a low pulse that lasts 8 oversamples is rejected.
- R4: The eight data bits are assembled least significant bit first, each one the majority of its oversamples 7, 8 and 9. A single inverted oversample at position 8 does not change the bit.
- R5: When the stop bit votes high, valid_o pulses high for exactly one clock, data_o shows the byte, and frame_err_o is 0.
- R6: When the stop bit votes low, frame_err_o is 1, and the byte is still shown on data_o with a one-clock valid_o pulse.
- R7: The receiver looks for the next start edge from oversample 10 of the stop bit onward, so a stop bit only 10 oversamples long followed directly by the next start bit is accepted.
- R8: A line transition between two data bits that is seen at oversample 15 ends the current bit one oversample early. One seen at oversample 1 of the next bit lengthens that bit by one oversample, at most once per bit. As a result, 0x55 sent with 15-oversample data bits decodes correctly.
- R9: Random bytes sent with each bit about 1.6 percent longer or shorter than nominal are received correctly.
- R10: data_o and frame_err_o change only in a cycle where valid_o is high. A rejected glitch leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Raw asynchronous receive line, idle high |
| baud_div_i | input | 16 | Oversample period minus one, in clocks |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-clock strobe when a byte is presented |
| frame_err_o | output | 1 | Stop bit of the presented byte voted low |

## Verification
The bench builds the receiver with its default parameters: 8 data bits, 16 oversamples per bit and a 16-bit divisor. At run time it drives baud_div_i from 0 to 4. With divisor 3, four clocks separate oversamples, so every bench edge lands on an exact oversample offset from the start edge. That makes it possible to place a line event on one chosen oversample: a spike at oversample 8, a start pulse of 8 oversamples, a stop bit cut to 10 oversamples, and data bits one oversample short or long. Divisor 0 covers an enable on every clock, and the random frames with about 1.6 percent rate error cover fractional drift.

// File: rtl/uart_os_rx_pkg.sv
// Package: shared state encoding and the bit voter for the serial receiver.
// Assumes a single clock domain downstream of the line synchroniser.
package uart_os_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three majority vote over the centre oversamples
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/ovs_tick_gen.sv
// Oversample enable generator: one single-cycle enable every div_i+1 clocks.
// Assumes div_i changes only while the receiver is idle.
module ovs_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt;

    assign tick_o = (cnt >= div_i);

    // Count clocks, wrap when the divisor is reached
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));

endmodule

// File: rtl/rx_line_sync.sv
// Line synchroniser: STAGES flops bring the raw line into the clock domain.
// Assumes the line idles high; every stage resets to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic line_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rx_i};
    end

    assign line_o = chain[STAGES-1];

endmodule

// File: rtl/rx_frame_ctrl.sv
// Frame controller: finds the start edge, votes every bit on its centre
// oversamples, shifts data in LSB first, moves the phase by one oversample
// on early/late edges between data bits and rearms in the middle of the stop bit.
// Assumes line_i is synchronous and tick_i is a single-cycle oversample enable.
module rx_frame_ctrl
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              line_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              ferr_o
);

    localparam int PH_W  = $clog2(OVS);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [PH_W-1:0]  PH_S0   = PH_W'(OVS/2 - 1);
    localparam logic [PH_W-1:0]  PH_S1   = PH_W'(OVS/2);
    localparam logic [PH_W-1:0]  PH_S2   = PH_W'(OVS/2 + 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OVS - 1);
    localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_t         state;
    logic [PH_W-1:0]   ph;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        smp;
    logic              prev_line;
    logic              adj_done;
    logic [DATA_W-1:0] shreg;
    logic              vote, edge_seen, fall, early, late;

    assign vote      = maj3(smp[0], smp[1], line_i);
    assign edge_seen = line_i ^ prev_line;
    assign fall      = prev_line & ~line_i;
    assign early     = edge_seen && (ph == PH_LAST) && (idx != IDX_LAST);
    assign late      = edge_seen && (ph == PH_ONE) && (idx != '0) && !adj_done;

    // Frame sequencing, voting, phase tracking and byte presentation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            ph        <= '0;
            idx       <= '0;
            smp       <= 2'b11;
            prev_line <= 1'b1;
            adj_done  <= 1'b0;
            shreg     <= '0;
            data_o    <= '0;
            valid_o   <= 1'b0;
            ferr_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (tick_i) begin
                prev_line <= line_i;
                if (ph == PH_S0) smp[0] <= line_i;
                if (ph == PH_S1) smp[1] <= line_i;
                unique case (state)
                    RX_IDLE: begin
                        if (fall) begin
                            state <= RX_START;
                            ph    <= PH_ONE;
                        end
                    end
                    RX_START: begin
                        ph <= ph + 1'b1;
                        if (ph == PH_S2 && vote) begin
                            state <= RX_IDLE;
                        end else if (ph == PH_LAST) begin
                            state    <= RX_DATA;
                            ph       <= '0;
                            idx      <= '0;
                            adj_done <= 1'b0;
                        end
                    end
                    RX_DATA: begin
                        if (ph == PH_S2) shreg <= {vote, shreg[DATA_W-1:1]};
                        if (early) begin
                            idx      <= idx + 1'b1;
                            ph       <= PH_ONE;
                            adj_done <= 1'b0;
                        end else if (late) begin
                            adj_done <= 1'b1;
                        end else if (ph == PH_LAST) begin
                            ph       <= '0;
                            adj_done <= 1'b0;
                            if (idx == IDX_LAST) state <= RX_STOP;
                            else                 idx   <= idx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        ph <= ph + 1'b1;
                        if (ph == PH_S2) begin
                            data_o  <= shreg;
                            valid_o <= 1'b1;
                            ferr_o  <= ~vote;
                            state   <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R5
    valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> ($past(state) == RX_STOP));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(data_o) || !$stable(ferr_o)) |-> valid_o);

    // R3
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE) |=> (state == RX_IDLE || state == RX_START));

endmodule

// File: rtl/uart_os_rx.sv
// Top: oversampling serial byte receiver. Synchronises the line, generates
// the 16x oversample enable and runs the frame controller.
// Assumes baud_div_i is stable while a frame is in flight.
module uart_os_rx #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic [DIV_W-1:0]  baud_div_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              frame_err_o
);

    logic tick, line;

    ovs_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick)
    );

    rx_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .line_o(line)
    );

    rx_frame_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line),
        .data_o(data_o), .valid_o(valid_o), .ferr_o(frame_err_o)
    );

endmodule

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [15:0] div = 16'd3;
    logic [7:0]  data_o;
    logic        valid_o, frame_err_o;

    int checks = 0;
    int fails  = 0;
    int got_cnt = 0;
    logic [7:0] got_data [0:255];
    logic       got_ferr [0:255];
    bit done = 0;

    always #2 clk = ~clk;

    uart_os_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(div),
        .data_o(data_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
    );

    // Log every presented byte, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && valid_o && got_cnt < 256) begin
            got_data[got_cnt] = data_o;
            got_ferr[got_cnt] = frame_err_o;
            got_cnt = got_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    // One oversample in clocks for the current divisor
    function automatic int tk();
        return int'(div) + 1;
    endfunction

    task automatic send_frame(input logic [7:0] b, input int st, input int dc,
                              input int sp, input logic spv, input int gap);
        hold(1'b0, st);
        for (int i = 0; i < 8; i++) hold(b[i], dc);
        hold(spv, sp);
        hold(1'b1, gap);
    endtask

    task automatic expect_one(input int base, input logic [7:0] e,
                              input logic ef, input string req);
        chk(got_cnt == base + 1, req, "byte count", got_cnt, base + 1);
        if (got_cnt > base) begin
            chk(got_data[base] == e, req, "data", got_data[base], e);
            chk(got_ferr[base] == ef, req, "frame error", got_ferr[base], ef);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(valid_o == 1'b0, "R1", "valid", valid_o, 0);
        chk(data_o == 8'h00, "R1", "data", data_o, 0);
        chk(frame_err_o == 1'b0, "R1", "frame error", frame_err_o, 0);
        rst_n = 1'b1;
        hold(1'b1, 40);

        begin : directed
            int b, t;
            logic [7:0] prev_data;
            t = tk();
            // R2 R5: nominal frame
            b = got_cnt;
            send_frame(8'hA5, 16*t, 16*t, 16*t, 1'b1, 8*t);
            expect_one(b, 8'hA5, 1'b0, "R5");

            // R3 R10: 8-oversample low pulse rejected, outputs untouched
            b = got_cnt;
            prev_data = data_o;
            hold(1'b0, 8*t);
            hold(1'b1, 200*t);
            chk(got_cnt == b, "R3", "glitch byte count", got_cnt, b);
            chk(data_o == prev_data, "R10", "data after glitch", data_o, prev_data);
            b = got_cnt;
            send_frame(8'h3E, 16*t, 16*t, 16*t, 1'b1, 8*t);
            expect_one(b, 8'h3E, 1'b0, "R3");

            // R4: single-oversample spike at oversample 8 of bit 3
            b = got_cnt;
            hold(1'b0, 16*t);
            hold(1'b0, 48*t);
            hold(1'b0, 8*t); hold(1'b1, t); hold(1'b0, 7*t);
            hold(1'b0, 64*t);
            hold(1'b1, 24*t);
            expect_one(b, 8'h00, 1'b0, "R4");

            // R6: stop bit low for 10 oversamples
            b = got_cnt;
            send_frame(8'h3C, 16*t, 16*t, 10*t, 1'b0, 40*t);
            expect_one(b, 8'h3C, 1'b1, "R6");
            b = got_cnt;
            send_frame(8'hC3, 16*t, 16*t, 16*t, 1'b1, 8*t);
            expect_one(b, 8'hC3, 1'b0, "R6");

            // R7: stop cut to 10 oversamples, next start right after
            b = got_cnt;
            send_frame(8'h81, 16*t, 16*t, 10*t, 1'b1, 0);
            send_frame(8'h7E, 16*t, 16*t, 16*t, 1'b1, 8*t);
            chk(got_cnt == b + 2, "R7", "byte count", got_cnt, b + 2);
            if (got_cnt >= b + 2) begin
                chk(got_data[b] == 8'h81, "R7", "first byte", got_data[b], 8'h81);
                chk(got_data[b+1] == 8'h7E, "R7", "second byte", got_data[b+1], 8'h7E);
            end

            // R8: data bits one oversample short, then one long
            b = got_cnt;
            send_frame(8'h55, 16*t, 15*t, 16*t, 1'b1, 8*t);
            expect_one(b, 8'h55, 1'b0, "R8");
            b = got_cnt;
            send_frame(8'hAA, 16*t, 17*t, 17*t, 1'b1, 8*t);
            expect_one(b, 8'hAA, 1'b0, "R8");
        end

        // R9 R2: random bytes, divisors and rate error
        for (int n = 0; n < 24; n++) begin
            int b, bc, d;
            logic [7:0] v;
            div = 16'($urandom_range(0, 4));
            hold(1'b1, 20);
            bc = 16 * tk();
            d = bc / 64;
            bc = ($urandom_range(0, 1) == 1) ? bc + d : bc - d;
            v = 8'($urandom);
            b = got_cnt;
            send_frame(v, bc, bc, bc, 1'b1, 4 * tk() + 10);
            expect_one(b, v, 1'b0, "R9");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule